// File: doc/BRIEF.md
# DMA Control and Status Register Bank

This block holds the software-visible registers of a two-channel DMA engine. One channel reads from memory and the other writes to memory. Software reaches the bank through a simple register port that carries single 32-bit reads and writes. Addresses on that port are byte addresses, and the bank drops the two low address bits to form a word index. The register contents drive the two address generators directly: start, loop and sync-disable controls, plus the start address, line length, line count and stride of each channel.

The address generators report back to the bank in two ways. A busy level from each channel can be read through the status word. A done pulse from each channel latches a sticky interrupt flag. Software clears a flag by writing a 1 to its bit. A per-channel mask gates each flag onto a single interrupt line.

A start bit behaves as a one-cycle command unless that channel's loop bit is set. In loop mode the start bit stays set until software clears it.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset every register reads zero except the version word, every control and geometry output is zero, and `irq_o` is 0.
- R2: The word index is `addr_i >> 2`, and the two low address bits are ignored. The indices are: 0 control, 1 status, 2 interrupt mask, 3 interrupt status, 4..7 read-channel base/length/count/stride, 8..11 write-channel base/length/count/stride, 12 version, 13 configuration.
- R3: A write to a geometry or configuration index is stored, appears on the matching output after the write edge, and reads back unchanged.
- R4: Control bits are: bit0 read start, bit1 write start, bit2 read sync-disable, bit3 write sync-disable, bit4 read loop, bit5 write loop. A start bit set by a write is high for exactly one cycle when its channel's loop bit is 0.
- R5: A start bit stays high while its channel's loop bit is 1, until software writes the control word again.
- R6: The sync-disable and loop bits drive their outputs and keep the written value until the next control write.
- R7: The status word returns the read-channel busy input in bit0 and the write-channel busy input in bit1. Writes to the status word have no effect.
- R8: Interrupt status bit0 (read channel) and bit1 (write channel) are set by the matching done pulse. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a done pulse arrives in the same cycle as a clear of that bit, the bit stays set.
- R9: `irq_o` is 1 exactly when some interrupt status bit and its mask bit are both 1. Mask bit0 covers the read channel and bit1 covers the write channel.
- R10: The version word always reads as the `VERSION` parameter, and writes to it are ignored.
- R11: An access to index 14 or above reads zero and changes no register.
- R12: Read data is registered. `rdata_o` shows the addressed word one cycle after the `rd_en_i` edge and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | AW | Byte address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| rd_busy_i | input | 1 | Read channel busy |
| wr_busy_i | input | 1 | Write channel busy |
| rd_done_i | input | 1 | Read channel completion pulse |
| wr_done_i | input | 1 | Write channel completion pulse |
| rd_start_o | output | 1 | Read channel start |
| wr_start_o | output | 1 | Write channel start |
| rd_nosync_o | output | 1 | Read channel sync disable |
| wr_nosync_o | output | 1 | Write channel sync disable |
| rd_loop_o | output | 1 | Read channel loop mode |
| wr_loop_o | output | 1 | Write channel loop mode |
| rd_base_o | output | DW | Read channel start address |
| rd_len_o | output | DW | Read channel line length |
| rd_cnt_o | output | DW | Read channel line count |
| rd_stride_o | output | DW | Read channel stride |
| wr_base_o | output | DW | Write channel start address |
| wr_len_o | output | DW | Write channel line length |
| wr_cnt_o | output | DW | Write channel line count |
| wr_stride_o | output | DW | Write channel stride |
| cfg_o | output | DW | Configuration word |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
Every register result lands one edge after its stimulus:
- a write's effect on an output, an interrupt flag or `irq_o` is visible after the write edge;
- read data appears after the read edge;
- a start bit drops one edge after the one that set it.

The bench drives inputs on the falling edge and samples on the following falling edge. Each check therefore sees exactly one rising edge between stimulus and sample. The start self-clear check looks at two consecutive falling edges to confirm a high of exactly one cycle. The same-cycle set-versus-clear case drives the done pulse and the clearing write into the same edge.

// File: rtl/dma_csr_bank.sv
module dma_csr_bank #(
  parameter int          NREG    = 14,
  parameter int          DW      = 32,
  parameter int          AW      = 8,
  parameter logic [31:0] VERSION = 32'h0001_0002
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rd_busy_i,
  input  logic          wr_busy_i,
  input  logic          rd_done_i,
  input  logic          wr_done_i,
  output logic          rd_start_o,
  output logic          wr_start_o,
  output logic          rd_nosync_o,
  output logic          wr_nosync_o,
  output logic          rd_loop_o,
  output logic          wr_loop_o,
  output logic [DW-1:0] rd_base_o,
  output logic [DW-1:0] rd_len_o,
  output logic [DW-1:0] rd_cnt_o,
  output logic [DW-1:0] rd_stride_o,
  output logic [DW-1:0] wr_base_o,
  output logic [DW-1:0] wr_len_o,
  output logic [DW-1:0] wr_cnt_o,
  output logic [DW-1:0] wr_stride_o,
  output logic [DW-1:0] cfg_o,
  output logic          irq_o
);
  localparam int IXW = AW - 2;
  localparam logic [IXW-1:0] IX_CTRL = IXW'(0);
  localparam logic [IXW-1:0] IX_STAT = IXW'(1);
  localparam logic [IXW-1:0] IX_MASK = IXW'(2);
  localparam logic [IXW-1:0] IX_ISR  = IXW'(3);
  localparam logic [IXW-1:0] IX_GEO  = IXW'(4);
  localparam logic [IXW-1:0] IX_VER  = IXW'(12);
  localparam logic [IXW-1:0] IX_CFG  = IXW'(13);
  localparam int NGEO = 8;

  wire [IXW-1:0] idx = addr_i[AW-1:2];
  wire           hit = idx < IXW'(NREG);
  wire           wr  = wr_en_i && hit;

  logic [5:0]    ctrl;
  logic [1:0]    mask, isr;
  logic [DW-1:0] geo [NGEO];
  logic [DW-1:0] cfg;
  logic [DW-1:0] rd_val;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (wr && idx == IX_CTRL) ctrl <= wdata_i[5:0];
    else begin
      if (!ctrl[4]) ctrl[0] <= 1'b0;
      if (!ctrl[5]) ctrl[1] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else if (wr && idx == IX_MASK) mask <= wdata_i[1:0];
  end

  wire [1:0] clr = (wr && idx == IX_ISR) ? wdata_i[1:0] : 2'b00;
  always_ff @(posedge clk) begin
    if (!rst_n) isr <= '0;
    else isr <= (isr & ~clr) | {wr_done_i, rd_done_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NGEO; i++) geo[i] <= '0;
      cfg <= '0;
    end else if (wr) begin
      for (int i = 0; i < NGEO; i++)
        if (idx == IX_GEO + IXW'(i)) geo[i] <= wdata_i;
      if (idx == IX_CFG) cfg <= wdata_i;
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit) begin
      if (idx == IX_CTRL)      rd_val = DW'(ctrl);
      else if (idx == IX_STAT) rd_val = DW'({wr_busy_i, rd_busy_i});
      else if (idx == IX_MASK) rd_val = DW'(mask);
      else if (idx == IX_ISR)  rd_val = DW'(isr);
      else if (idx == IX_VER)  rd_val = DW'(VERSION);
      else if (idx == IX_CFG)  rd_val = cfg;
      else if (idx >= IX_GEO && idx < IX_GEO + IXW'(NGEO))
        rd_val = geo[3'(idx - IX_GEO)];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  assign {wr_loop_o, rd_loop_o, wr_nosync_o, rd_nosync_o, wr_start_o, rd_start_o} = ctrl;
  assign rd_base_o   = geo[0];
  assign rd_len_o    = geo[1];
  assign rd_cnt_o    = geo[2];
  assign rd_stride_o = geo[3];
  assign wr_base_o   = geo[4];
  assign wr_len_o    = geo[5];
  assign wr_cnt_o    = geo[6];
  assign wr_stride_o = geo[7];
  assign cfg_o       = cfg;
  assign irq_o       = |(isr & mask);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start_o && !rd_loop_o && !wr_en_i) |=> !rd_start_o); // R4
  AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start_o && wr_loop_o && !wr_en_i) |=> wr_start_o); // R5
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done_i |=> isr[0]); // R8
  AST_VER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && idx == IX_VER) |=> rdata_o == DW'(VERSION)); // R10
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !hit) |=> rdata_o == '0); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o)); // R12
endmodule

// File: tb/sim_dma_csr_bank.sv
module sim_dma_csr_bank;
  localparam logic [31:0] VER = 32'h0001_0002;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic rd_busy = 0, wr_busy = 0, rd_done = 0, wr_done = 0;
  logic rd_start, wr_start, rd_nosync, wr_nosync, rd_loop, wr_loop, irq;
  logic [31:0] rb, rl, rc, rs, wb, wl, wc, ws, cfg;
  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] m_geo [8];
  logic [31:0] m_cfg;
  logic [1:0]  m_mask;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_csr_bank u0 (.clk, .rst_n, .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rd_busy_i(rd_busy), .wr_busy_i(wr_busy),
    .rd_done_i(rd_done), .wr_done_i(wr_done), .rd_start_o(rd_start), .wr_start_o(wr_start),
    .rd_nosync_o(rd_nosync), .wr_nosync_o(wr_nosync), .rd_loop_o(rd_loop), .wr_loop_o(wr_loop),
    .rd_base_o(rb), .rd_len_o(rl), .rd_cnt_o(rc), .rd_stride_o(rs), .wr_base_o(wb),
    .wr_len_o(wl), .wr_cnt_o(wc), .wr_stride_o(ws), .cfg_o(cfg), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int ix, logic [31:0] d, logic [1:0] lo = 2'b00);
    @(negedge clk); wr_en = 1; addr = 8'((ix << 2) | lo); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int ix, output logic [31:0] d, input logic [1:0] lo = 2'b00);
    @(negedge clk); rd_en = 1; addr = 8'((ix << 2) | lo);
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  function automatic logic [31:0] exp_rd(int ix, logic [1:0] busy);
    if (ix == 1) return {30'd0, busy};
    if (ix == 2) return {30'd0, m_mask};
    if (ix == 3) return 32'd0;
    if (ix >= 4 && ix <= 11) return m_geo[ix-4];
    if (ix == 12) return VER;
    if (ix == 13) return m_cfg;
    return 32'd0;
  endfunction

  initial begin
    logic [31:0] v, held;
    process::self().srandom(32'd7);
    for (int i = 0; i < 8; i++) m_geo[i] = 0;
    m_cfg = 0; m_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 outputs", {rd_start, wr_start, rd_nosync, wr_nosync, rd_loop, wr_loop, irq}, 0);
    chk("R1 geometry", rb | ws | cfg, 0);
    rd(0, v); chk("R1 ctrl", v, 0);

    wr(0, 32'h01);
    chk("R4 start high", rd_start, 1);
    @(negedge clk); chk("R4 start cleared", rd_start, 0);

    wr(0, 32'h22);
    repeat (4) @(negedge clk);
    chk("R5 loop start held", wr_start, 1);
    chk("R6 loop out", {wr_loop, rd_loop}, 2'b10);
    wr(0, 32'h0C);
    chk("R5 start stops", wr_start, 0);
    repeat (3) @(negedge clk);
    chk("R6 nosync held", {wr_nosync, rd_nosync, wr_loop}, 3'b110);
    wr(0, 0);

    wr(4, 32'hA5A5_0001, 2'b11);
    chk("R3 output", rb, 32'hA5A5_0001); m_geo[0] = 32'hA5A5_0001;
    rd(4, v, 2'b10); chk("R2 low bits ignored", v, 32'hA5A5_0001);
    held = v;
    repeat (2) @(negedge clk);
    wr(4, 32'h1234);
    chk("R12 rdata held", rdata, held); m_geo[0] = 32'h1234;

    wr(12, 32'hFFFF_FFFF); rd(12, v); chk("R10 version", v, VER);
    wr(1, 32'h3); rd(1, v); chk("R7 status write ignored", v, 0);
    rd_busy = 1; rd(1, v); chk("R7 busy read", v, 1); rd_busy = 0;

    @(negedge clk); rd_done = 1; @(negedge clk); rd_done = 0;
    rd(3, v); chk("R8 done sets", v, 1);
    chk("R9 masked off", irq, 0);
    wr(2, 32'h1); chk("R9 irq on", irq, 1);
    wr(3, 32'h2); rd(3, v); chk("R8 write 0 keeps", v, 1);
    wr(3, 32'h1); chk("R9 irq off after clear", irq, 0);
    rd(3, v); chk("R8 w1c", v, 0);
    wr(2, 32'h2);
    @(negedge clk); wr_done = 1; wr_en = 1; addr = 8'd12; wdata = 32'h2;
    @(negedge clk); wr_done = 0; wr_en = 0;
    rd(3, v); chk("R8 set wins", v, 2);
    chk("R9 irq write ch", irq, 1);
    wr(3, 32'h3); m_mask = 2'b10;

    wr(14, 32'hDEAD); rd(14, v); chk("R11 oor read", v, 0);
    chk("R11 no alias", rb | cfg, 32'h1234);

    for (int n = 0; n < 400; n++) begin
      int ix = 1 + int'($urandom_range(0, 14));
      logic [1:0] lo = 2'($urandom);
      logic [31:0] d = $urandom;
      if ($urandom_range(0, 1) == 0) begin
        wr(ix, d, lo);
        if (ix >= 4 && ix <= 11) m_geo[ix-4] = d;
        if (ix == 13) m_cfg = d;
        if (ix == 2) m_mask = d[1:0];
        chk("R3 outputs track", rs ^ wc ^ cfg, m_geo[3] ^ m_geo[6] ^ m_cfg);
      end else begin
        logic [1:0] b = 2'($urandom);
        {wr_busy, rd_busy} = b;
        rd(ix, v, lo);
        chk(ix >= 14 ? "R11 random" : "R2 random read", v, exp_rd(ix, b));
      end
    end
    chk("R9 no irq", irq, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule